// File: doc/BRIEF.md
# Bus Master Termination and Retry Controller

This block runs one external bus transfer on behalf of a requesting master. The master hands over a read or write with an address, a small attribute field and write data. The controller then wins the bus, drives the transfer and waits for it to end. The transfer can end in one of three ways. The target can acknowledge it. An error can be raised, either by one of several wired-OR error sources or by the built-in bus monitor when no acknowledge arrives in time. The target can also ask for the transfer to be retried. When the master-side interface sees done or error, it knows the transfer is over. For a read that was acknowledged, the captured data is held on the read-data output.

On a retry, the controller gives up the bus for exactly one clock and then arbitrates again. It then reissues the same transfer: the same address, the same attributes and, for a write, the same data. The release sequence depends on the arbitration mode. With the internal arbiter, the block itself grants the bus to other masters. With an external arbiter, it requests the bus and waits for the grant. The mode is selected by a static input.

Top module: `busterm_ctrl`

## Requirements
- R1: A request is taken only while `req_ready` is high. After the transfer is acknowledged, `done_o` is high for exactly the one clock that follows the acknowledge cycle. For a read, `rd_data_o` then holds the `bus_din` value sampled with the acknowledge.
- R2: While the transfer is on the bus, the address, attributes, write flag and write data stay equal to the accepted request. `bus_ts_o` marks the first bus clock of each attempt. A request raised while the block is not ready changes nothing.
- R3: If an attempt receives no termination, the bus monitor ends it as an error in its TIMEOUT-th bus clock. `err_o` is then high for the one following clock.
- R4: When a transfer error and an acknowledge are sampled in the same clock, the transfer ends as an error and `done_o` stays low.
- R5: The error input is the OR of every bit of `bus_tea_i`, so any single source that is high terminates the transfer.
- R6: After an error termination with the error still high, the error input is ignored until it has been seen low. A transfer started while the error is still high completes normally on acknowledge.
- R7: A retry ends the attempt without done or error, and the identical transfer is reissued. `rty_cnt_o` counts the retries of the current request, saturates at its all-ones value and is cleared when a new request is accepted.
- R8: In internal mode (`ext_arb`=0), the clock after a retry has `bus_bb_o` low and `bus_bg_o` high. The clock after that is a normal arbitration clock.
- R9: In external mode (`ext_arb`=1), the clock after a retry has both `bus_br_o` and `bus_bb_o` low. In the next clock, `bus_br_o` is high again.
- R10: When terminations coincide, error beats retry and retry beats acknowledge. A retry with an acknowledge produces no done. An error with a retry produces no release and does not raise the retry count.
- R11: `bus_bb_o` is high in every clock of an owned attempt and in no other clock. An attempt starts only when `bus_bb_i` is low and either `bus_br_i` is low (internal mode) or `bus_bg_i` is high (external mode). In internal mode, `bus_bg_o` is high while another master requests the bus during arbitration.
- R12: The bus monitor restarts its count for every attempt, so a reissued attempt again gets the full TIMEOUT clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe from the master |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request address |
| req_attr | input | ATW | Request attributes |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| done_o | output | 1 | One-clock pulse: transfer acknowledged |
| err_o | output | 1 | One-clock pulse: transfer ended in error |
| rty_cnt_o | output | RCW | Retries seen for the current request |
| rd_data_o | output | DW | Data of the last acknowledged read |
| ext_arb | input | 1 | 1 selects external-arbiter mode |
| bus_br_o | output | 1 | Bus request to an external arbiter |
| bus_bg_i | input | 1 | Grant from the external arbiter |
| bus_br_i | input | 1 | Request from another master (internal mode) |
| bus_bg_o | output | 1 | Grant to another master (internal mode) |
| bus_bb_i | input | 1 | Bus busy driven by another master |
| bus_bb_o | output | 1 | Bus busy while this block owns the bus |
| bus_ts_o | output | 1 | First clock of an attempt |
| bus_addr_o | output | AW | Bus address |
| bus_attr_o | output | ATW | Bus attributes |
| bus_wr_o | output | 1 | Bus write flag |
| bus_dout_o | output | DW | Bus write data |
| bus_din | input | DW | Bus read data |
| bus_ta_i | input | 1 | Transfer acknowledge |
| bus_tea_i | input | NSRC | Transfer error sources, OR-combined |
| bus_retry_i | input | 1 | Retry request |

## Verification
The bench builds the block with TIMEOUT=6, RCW=3, two error sources and 16-bit address and data paths. The short timeout means the monitor expires, including after a reissue, within a handful of clocks. The 3-bit counter reaches saturation after seven retries. Two error sources are enough to show that either one alone ends a transfer. Both arbitration modes are run in the same build by switching `ext_arb` between transfers.

// File: rtl/busterm_pkg.sv
`timescale 1ns/1ps
// busterm_pkg: shared state and termination encodings for the bus
// termination controller. Assumes a single outstanding transfer.
package busterm_pkg;

    // Controller phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } st_e;

    // Resolved termination of the current bus clock
    typedef enum logic [1:0] {
        TM_NONE  = 2'd0,
        TM_ACK   = 2'd1,
        TM_RETRY = 2'd2,
        TM_ERR   = 2'd3
    } term_e;

endpackage

// File: rtl/busterm_errq.sv
`timescale 1ns/1ps
// busterm_errq: OR-combines the error sources and qualifies the result.
// An error that was high when a transfer ended in error disarms the input
// until the combined error has been seen low at least once.
// Assumes err_end is high only in a clock whose termination is an error.
module busterm_errq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tea_src,
    input  logic            err_end,
    output logic            tea_eff
);

    logic tea_any;
    logic armed_q;

    // wired-OR of every error source
    assign tea_any = |tea_src;

    // arm once the error is low, disarm when an error ends a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!tea_any) begin
            armed_q <= 1'b1;
        end else if (err_end) begin
            armed_q <= 1'b0;
        end
    end

    assign tea_eff = tea_any & armed_q;

endmodule

// File: rtl/busterm_mon.sv
`timescale 1ns/1ps
// busterm_mon: bus monitor. Counts the clocks of one attempt and flags
// expiry in the TIMEOUT-th clock. Held at zero whenever no attempt runs,
// so every attempt starts from a cleared count. Assumes TIMEOUT >= 1.
module busterm_mon #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TMW = $clog2(TIMEOUT + 1);
    localparam logic [TMW-1:0] LAST = TMW'(TIMEOUT - 1);

    logic [TMW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    // count clocks of the running attempt, clear outside of it
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/busterm_arb.sv
`timescale 1ns/1ps
// busterm_arb: arbitration glue for both modes. Decides when the
// controller may start an attempt and drives request or grant lines.
// Assumes ext_arb stays constant while a request is in progress.
module busterm_arb
    import busterm_pkg::*;
(
    input  st_e  st,
    input  logic ext_arb,
    input  logic bus_bg_i,
    input  logic bus_br_i,
    input  logic bus_bb_i,
    output logic win,
    output logic bus_br_o,
    output logic bus_bg_o
);

    logic arbing;

    assign arbing = (st == ST_ARB);

    // take the bus when it is idle and the mode's condition holds
    always_comb begin
        if (ext_arb) begin
            win = arbing && !bus_bb_i && bus_bg_i;
        end else begin
            win = arbing && !bus_bb_i && !bus_br_i;
        end
    end

    // external mode: request while arbitrating, dropped during release
    assign bus_br_o = ext_arb && arbing;

    // internal mode: grant a requester, and always grant in release clock
    assign bus_bg_o = !ext_arb && ((arbing && bus_br_i) || (st == ST_REL));

endmodule

// File: rtl/busterm_ctrl.sv
`timescale 1ns/1ps
// busterm_ctrl: top of the bus termination and retry controller.
// Accepts one request at a time, arbitrates, drives the attempt, resolves
// termination (error > retry > acknowledge), releases the bus for one clock
// on retry and reissues the held transfer.
// Assumes bus inputs are synchronous to clk.
module busterm_ctrl
    import busterm_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int ATW     = 4,
    parameter int NSRC    = 2,
    parameter int TIMEOUT = 64,
    parameter int RCW     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [ATW-1:0]  req_attr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ready,
    output logic            done_o,
    output logic            err_o,
    output logic [RCW-1:0]  rty_cnt_o,
    output logic [DW-1:0]   rd_data_o,
    input  logic            ext_arb,
    output logic            bus_br_o,
    input  logic            bus_bg_i,
    input  logic            bus_br_i,
    output logic            bus_bg_o,
    input  logic            bus_bb_i,
    output logic            bus_bb_o,
    output logic            bus_ts_o,
    output logic [AW-1:0]   bus_addr_o,
    output logic [ATW-1:0]  bus_attr_o,
    output logic            bus_wr_o,
    output logic [DW-1:0]   bus_dout_o,
    input  logic [DW-1:0]   bus_din,
    input  logic            bus_ta_i,
    input  logic [NSRC-1:0] bus_tea_i,
    input  logic            bus_retry_i
);

    localparam logic [RCW-1:0] RC_MAX = '1;

    st_e            st_q;
    term_e          term;
    logic           first_q;
    logic           done_q;
    logic           err_q;
    logic [RCW-1:0] rcnt_q;
    logic [DW-1:0]  rdata_q;
    logic [AW-1:0]  addr_q;
    logic [ATW-1:0] attr_q;
    logic           wr_q;
    logic [DW-1:0]  wd_q;
    logic           tea_eff;
    logic           expired;
    logic           arb_win;
    logic           in_xfer;

    assign in_xfer = (st_q == ST_XFER);

    busterm_errq #(.NSRC(NSRC)) u_errq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tea_src (bus_tea_i),
        .err_end (term == TM_ERR),
        .tea_eff (tea_eff)
    );

    busterm_mon #(.TIMEOUT(TIMEOUT)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_xfer),
        .expired (expired)
    );

    busterm_arb u_arb (
        .st       (st_q),
        .ext_arb  (ext_arb),
        .bus_bg_i (bus_bg_i),
        .bus_br_i (bus_br_i),
        .bus_bb_i (bus_bb_i),
        .win      (arb_win),
        .bus_br_o (bus_br_o),
        .bus_bg_o (bus_bg_o)
    );

    // resolve the termination of this bus clock by priority
    always_comb begin
        term = TM_NONE;
        if (in_xfer) begin
            if (tea_eff || expired) begin
                term = TM_ERR;
            end else if (bus_retry_i) begin
                term = TM_RETRY;
            end else if (bus_ta_i) begin
                term = TM_ACK;
            end
        end
    end

    // phase sequencing: idle, arbitrate, transfer, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) st_q <= ST_ARB;
                ST_ARB: begin
                    if (arb_win) begin
                        st_q    <= ST_XFER;
                        first_q <= 1'b1;
                    end
                end
                ST_XFER: begin
                    first_q <= 1'b0;
                    if (term == TM_RETRY) begin
                        st_q <= ST_REL;
                    end else if (term != TM_NONE) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_REL:  st_q <= ST_ARB;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // hold the accepted request for every attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            attr_q <= '0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
        end else if (st_q == ST_IDLE && req_valid) begin
            addr_q <= req_addr;
            attr_q <= req_attr;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
        end
    end

    // completion pulses, retry count and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rcnt_q  <= '0;
            rdata_q <= '0;
        end else begin
            done_q <= (term == TM_ACK);
            err_q  <= (term == TM_ERR);
            if (st_q == ST_IDLE && req_valid) begin
                rcnt_q <= '0;
            end else if (term == TM_RETRY && rcnt_q != RC_MAX) begin
                rcnt_q <= rcnt_q + 1'b1;
            end
            if (term == TM_ACK && !wr_q) begin
                rdata_q <= bus_din;
            end
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign rty_cnt_o  = rcnt_q;
    assign rd_data_o  = rdata_q;
    assign bus_bb_o   = in_xfer;
    assign bus_ts_o   = in_xfer && first_q;
    assign bus_addr_o = addr_q;
    assign bus_attr_o = attr_q;
    assign bus_wr_o   = wr_q;
    assign bus_dout_o = wd_q;

endmodule

// File: rtl/busterm_chk.sv
`timescale 1ns/1ps
// busterm_chk: protocol checker bound to busterm_ctrl. Observes ports and
// the resolved termination; drives nothing.
module busterm_chk
    import busterm_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int TIMEOUT = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_arb,
    input logic          bus_bb_o,
    input logic          bus_bg_o,
    input logic          bus_br_o,
    input logic          bus_ta_i,
    input logic [AW-1:0] bus_addr_o,
    input logic [DW-1:0] bus_dout_o,
    input logic          done_o,
    input logic          err_o,
    input term_e         term,
    input logic          tea_eff
);

    int unsigned run_q;

    // consecutive bus-busy clocks seen so far
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_bb_o) begin
            run_q <= 0;
        end else begin
            run_q <= run_q + 1;
        end
    end

    // R3: an attempt never outlasts the monitor window
    a_r3_monitor_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bb_o |-> (run_q < TIMEOUT));

    // R1: done only follows an owned clock carrying an acknowledge
    a_r1_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bus_bb_o && bus_ta_i) && !err_o));

    // R2: request fields stay put across an attempt
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bb_o && $past(bus_bb_o)) |-> ($stable(bus_addr_o) && $stable(bus_dout_o)));

    // R4: a qualified error always ends in an error pulse
    a_r4_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bb_o && tea_eff) |=> (err_o && !done_o));

    // R8: internal mode release clock
    a_r8_int_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bb_o && term == TM_RETRY && !ext_arb) |=> (!bus_bb_o && bus_bg_o));

    // R9: external mode release then request again
    a_r9_ext_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bb_o && term == TM_RETRY && ext_arb) |=> (!bus_bb_o && !bus_br_o) ##1 bus_br_o);

endmodule

bind busterm_ctrl busterm_chk #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_arb    (ext_arb),
    .bus_bb_o   (bus_bb_o),
    .bus_bg_o   (bus_bg_o),
    .bus_br_o   (bus_br_o),
    .bus_ta_i   (bus_ta_i),
    .bus_addr_o (bus_addr_o),
    .bus_dout_o (bus_dout_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .term       (term),
    .tea_eff    (tea_eff)
);

// File: tb/tb_busterm_ctrl.sv
`timescale 1ns/1ps
module tb_busterm_ctrl;

    localparam int AW = 16, DW = 16, ATW = 3, NSRC = 2, TO = 6, RCW = 3;
    localparam int RMAX = (1 << RCW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [ATW-1:0] req_attr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, done_o, err_o;
    logic [RCW-1:0] rty_cnt_o;
    logic [DW-1:0] rd_data_o;
    logic ext_arb = 0, bus_bg_i = 0, bus_br_i = 0, bus_bb_i = 0;
    logic bus_br_o, bus_bg_o, bus_bb_o, bus_ts_o, bus_wr_o;
    logic [AW-1:0] bus_addr_o;
    logic [ATW-1:0] bus_attr_o;
    logic [DW-1:0] bus_dout_o;
    logic [DW-1:0] bus_din = '0;
    logic bus_ta_i = 0, bus_retry_i = 0;
    logic [NSRC-1:0] bus_tea_i = '0;

    int checks = 0, bad = 0;

    busterm_ctrl #(.AW(AW), .DW(DW), .ATW(ATW), .NSRC(NSRC), .TIMEOUT(TO), .RCW(RCW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_attr(req_attr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done_o(done_o), .err_o(err_o), .rty_cnt_o(rty_cnt_o),
        .rd_data_o(rd_data_o), .ext_arb(ext_arb), .bus_br_o(bus_br_o), .bus_bg_i(bus_bg_i),
        .bus_br_i(bus_br_i), .bus_bg_o(bus_bg_o), .bus_bb_i(bus_bb_i), .bus_bb_o(bus_bb_o),
        .bus_ts_o(bus_ts_o), .bus_addr_o(bus_addr_o), .bus_attr_o(bus_attr_o),
        .bus_wr_o(bus_wr_o), .bus_dout_o(bus_dout_o), .bus_din(bus_din),
        .bus_ta_i(bus_ta_i), .bus_tea_i(bus_tea_i), .bus_retry_i(bus_retry_i)
    );

    always #2.5 clk = ~clk;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int ph = 0, nph = 0, cnt = 0, rc = 0;
    bit armed = 0, first = 0, md = 0, me = 0, anyt = 0, errt = 0, mwr = 0;
    logic [AW-1:0] ma = '0;
    logic [DW-1:0] mw = '0, mrd = '0;
    logic [ATW-1:0] mat = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; armed = 0; cnt = 0; first = 0; md = 0; me = 0; rc = 0; mrd = '0;
            ma = '0; mw = '0; mat = '0; mwr = 0;
        end else begin
            anyt = (bus_tea_i != '0);
            errt = (ph == 2) && ((armed && anyt) || cnt == TO - 1);
            nph = ph; md = 0; me = 0;
            case (ph)
                0: if (req_valid) begin
                    nph = 1; ma = req_addr; mw = req_wdata; mat = req_attr; mwr = req_write; rc = 0;
                end
                1: if (!bus_bb_i && (ext_arb ? bus_bg_i : !bus_br_i)) begin
                    nph = 2; first = 1;
                end
                2: begin
                    first = 0;
                    if (errt) begin nph = 0; me = 1; end
                    else if (bus_retry_i) begin nph = 3; if (rc < RMAX) rc++; end
                    else if (bus_ta_i) begin nph = 0; md = 1; if (!mwr) mrd = bus_din; end
                end
                default: nph = 1;
            endcase
            cnt = (ph == 2 && nph == 2) ? cnt + 1 : 0;
            armed = !anyt ? 1'b1 : (errt ? 1'b0 : armed);
            ph = nph;
        end
    end

    // per-clock comparison, half a unit after the falling edge
    always begin
        @(negedge clk);
        #0.5;
        if (rst_n) begin
            cmp("R11 bus_bb_o", 32'(bus_bb_o), 32'(ph == 2));
            cmp("R1 req_ready", 32'(req_ready), 32'(ph == 0));
            cmp("R2 bus_ts_o", 32'(bus_ts_o), 32'(ph == 2 && first));
            cmp("R9 bus_br_o", 32'(bus_br_o), 32'(ext_arb && ph == 1));
            cmp("R8 bus_bg_o", 32'(bus_bg_o), 32'(!ext_arb && ((ph == 1 && bus_br_i) || ph == 3)));
            cmp("R1 done_o", 32'(done_o), 32'(md));
            cmp("R3 err_o", 32'(err_o), 32'(me));
            cmp("R7 rty_cnt_o", 32'(rty_cnt_o), 32'(rc));
            cmp("R1 rd_data_o", 32'(rd_data_o), 32'(mrd));
            if (ph == 2) begin
                cmp("R2 bus_addr_o", 32'(bus_addr_o), 32'(ma));
                cmp("R2 bus_dout_o", 32'(bus_dout_o), 32'(mw));
                cmp("R2 bus_wr_o", 32'(bus_wr_o), 32'(mwr));
                cmp("R2 bus_attr_o", 32'(bus_attr_o), 32'(mat));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_attr = a[ATW-1:0];
        step();
        req_valid = 0;
    endtask

    task automatic wait_ts();
        for (int g = 0; g < 40 && !bus_ts_o; g++) step();
    endtask

    task automatic ack();
        bus_ta_i = 1; step(); bus_ta_i = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (bus_bb_o && n < 50) begin n++; step(); end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; bad++;
        $display("FAIL R11 watchdog act=hang exp=finish");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1;
        step();
        cmp("R1 reset ready", 32'(req_ready), 32'd1);
        cmp("R11 reset busy", 32'(bus_bb_o), 32'd0);

        // R1: read with two wait clocks
        issue(0, 16'h1234, 16'h0);
        wait_ts(); step(); step();
        cmp("R1 still open", 32'(bus_bb_o), 32'd1);
        bus_din = 16'hBEEF; ack();
        cmp("R1 done pulse", 32'(done_o), 32'd1);
        cmp("R1 read data", 32'(rd_data_o), 32'hBEEF);

        // R2: write fields and ignored request while busy
        issue(1, 16'h00A5, 16'h5A5A);
        wait_ts();
        cmp("R2 addr", 32'(bus_addr_o), 32'h00A5);
        cmp("R2 wdata", 32'(bus_dout_o), 32'h5A5A);
        req_valid = 1; req_addr = 16'h7777; step(); req_valid = 0;
        cmp("R2 addr unchanged", 32'(bus_addr_o), 32'h00A5);
        ack();
        cmp("R2 write done", 32'(done_o), 32'd1);
        step();
        cmp("R2 no extra transfer", 32'(req_ready), 32'd1);

        // R3: timeout
        issue(0, 16'h0300, 16'h0);
        wait_ts(); count_busy(n);
        cmp("R3 timeout err", 32'(err_o), 32'd1);
        cmp("R3 timeout length", 32'(n), 32'(TO));

        // R4: error and ack together, error left high
        issue(0, 16'h0400, 16'h0);
        wait_ts(); bus_tea_i = 2'b01; bus_ta_i = 1; step(); bus_ta_i = 0;
        cmp("R4 err wins", 32'(err_o), 32'd1);
        cmp("R4 no done", 32'(done_o), 32'd0);

        // R6: stale error ignored
        issue(0, 16'h0600, 16'h0);
        wait_ts(); step();
        cmp("R6 stale error ignored", 32'(bus_bb_o), 32'd1);
        bus_din = 16'h0606; ack();
        cmp("R6 done", 32'(done_o), 32'd1);
        cmp("R6 no err", 32'(err_o), 32'd0);
        bus_tea_i = '0; step();

        // R5: second source alone
        issue(0, 16'h0500, 16'h0);
        wait_ts(); bus_tea_i = 2'b10; step(); bus_tea_i = '0;
        cmp("R5 source1 err", 32'(err_o), 32'd1);

        // R7/R8: internal retry and reissue
        issue(1, 16'h0321, 16'hC0DE);
        wait_ts(); step();
        bus_retry_i = 1; step(); bus_retry_i = 0;
        cmp("R8 release bb", 32'(bus_bb_o), 32'd0);
        cmp("R8 release grant", 32'(bus_bg_o), 32'd1);
        step();
        cmp("R8 arb no grant", 32'(bus_bg_o), 32'd0);
        step();
        cmp("R7 reissue start", 32'(bus_ts_o), 32'd1);
        cmp("R7 same addr", 32'(bus_addr_o), 32'h0321);
        cmp("R7 same data", 32'(bus_dout_o), 32'hC0DE);
        cmp("R7 count", 32'(rty_cnt_o), 32'd1);
        ack();
        cmp("R7 done", 32'(done_o), 32'd1);

        // R12: monitor restarts on reissue
        issue(0, 16'h0120, 16'h0);
        wait_ts(); step(); step(); step();
        bus_retry_i = 1; step(); bus_retry_i = 0;
        wait_ts(); count_busy(n);
        cmp("R12 full window", 32'(n), 32'(TO));
        cmp("R12 err", 32'(err_o), 32'd1);

        // R10: priorities
        issue(0, 16'h0A00, 16'h0);
        wait_ts(); bus_retry_i = 1; bus_ta_i = 1; step(); bus_retry_i = 0; bus_ta_i = 0;
        cmp("R10 retry beats ack", 32'(done_o), 32'd0);
        cmp("R10 released", 32'(bus_bb_o), 32'd0);
        wait_ts(); bus_tea_i = 2'b01; bus_retry_i = 1; step(); bus_tea_i = '0; bus_retry_i = 0;
        cmp("R10 err beats retry", 32'(err_o), 32'd1);
        cmp("R10 count kept", 32'(rty_cnt_o), 32'd1);
        step();

        // R11: another master takes the bus after the release
        issue(0, 16'h0B00, 16'h0);
        wait_ts(); bus_retry_i = 1; step(); bus_retry_i = 0;
        bus_br_i = 1; step();
        cmp("R11 grant to requester", 32'(bus_bg_o), 32'd1);
        bus_br_i = 0; bus_bb_i = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            cmp("R11 waits on busy", 32'(bus_bb_o | bus_ts_o), 32'd0);
        end
        bus_bb_i = 0; step();
        cmp("R11 restart", 32'(bus_ts_o), 32'd1);
        ack();

        // R9: external arbiter
        ext_arb = 1; step();
        issue(0, 16'h0900, 16'h0);
        cmp("R9 request", 32'(bus_br_o), 32'd1);
        cmp("R9 no grant no start", 32'(bus_bb_o), 32'd0);
        bus_bg_i = 1; step();
        cmp("R9 start on grant", 32'(bus_ts_o), 32'd1);
        bus_retry_i = 1; step(); bus_retry_i = 0;
        cmp("R9 release br", 32'(bus_br_o), 32'd0);
        cmp("R9 release bb", 32'(bus_bb_o), 32'd0);
        step();
        cmp("R9 request again", 32'(bus_br_o), 32'd1);
        wait_ts(); ack();
        cmp("R9 done", 32'(done_o), 32'd1);
        ext_arb = 0; bus_bg_i = 0; step();

        // R7: saturation
        issue(0, 16'h0700, 16'h0);
        for (int k = 0; k < 9; k++) begin
            wait_ts(); bus_retry_i = 1; step(); bus_retry_i = 0;
        end
        wait_ts(); ack();
        cmp("R7 saturated", 32'(rty_cnt_o), 32'(RMAX));
        issue(0, 16'h0701, 16'h0);
        cmp("R7 cleared on accept", 32'(rty_cnt_o), 32'd0);
        wait_ts(); ack();
        step(); step();

        finish_run();
    end

endmodule